// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This block keeps the interrupt state of a bus controller. Eight event sources, from the transfer sequencer and from the register port, each give a one-cycle set pulse. A pulse sets a sticky bit in a 10-bit status register. Host software clears those bits by writing ones (write-one-to-clear).

The mask register cannot be written directly. Writing ones to the unmask port clears the matching mask bits. Writing ones to the mask port sets them. Neither port stores the value written. After reset the mask is 0x2FF, so every event is masked.

A single level interrupt line goes high when a status bit is set and its mask bit is clear. The line is registered. It follows a status or mask change one cycle later.

Top module: `irq_status_mask`

## Requirements
- R1: After reset the status reads 0x000, the mask reads 0x2FF and the interrupt line is low.
- R2: A pulse on event input i (0 complete, 1 data, 2 NACK, 3 timeout, 4 slave ready, 5 RX overflow, 6 TX overflow, 7 RX underflow) sets status bit i at the next clock edge, and the bit stays set until it is cleared.
- R3: A status write with a one in a bit of 0x2FF clears that status bit at the next edge. Bits written as zero keep their value.
- R4: Status bits 8 and 9 have no event source and always read zero, whatever is written to the status port.
- R5: An unmask write clears each mask bit whose written bit is one and leaves the other mask bits unchanged.
- R6: A mask write sets each mask bit whose written bit is one and leaves the other mask bits unchanged.
- R7: When the unmask and mask ports both target a mask bit in the same cycle, the bit ends up set (masked).
- R8: When an event pulse and a status clear hit the same bit in the same cycle, the bit ends up set.
- R9: At each clock edge the interrupt line takes the value of "any status bit set with its mask bit clear", computed from the status and mask held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| eventSet | input | 8 | One-cycle set pulses, one per event source |
| statusWrEn | input | 1 | Status clear write strobe |
| statusWrData | input | 10 | Bits to clear (write-one-to-clear) |
| unmaskWrEn | input | 1 | Unmask write strobe |
| unmaskWrData | input | 10 | Mask bits to clear |
| maskWrEn | input | 1 | Mask write strobe |
| maskWrData | input | 10 | Mask bits to set |
| statusQ | output | 10 | Current status register |
| maskQ | output | 10 | Current mask register |
| irqOut | output | 1 | Registered level interrupt |

## Verification
The hardest cases to reach are the same-cycle collisions: a set pulse and a clear on the same bit, and unmask and mask writes on the same bit. With independent random stimulus these collide only rarely. The bench drives them directly on chosen bits. The random phase also biases writes to all-ones patterns, so collisions happen often. The one-cycle lag of the interrupt line is checked every cycle against a model that computes the line from the state held before each edge.

// File: rtl/irq_status_mask_pkg.sv
package irq_status_mask_pkg;
  localparam int StatW = 10;
  localparam int EvtW  = 8;
  localparam logic [StatW-1:0] ClearableBits = 10'h2FF;
  localparam logic [StatW-1:0] MaskResetVal  = 10'h2FF;

  typedef struct packed {
    logic [StatW-1:0] clrBits;
    logic [StatW-1:0] unmaskBits;
    logic [StatW-1:0] maskBits;
  } ctrlStrobes_t;
endpackage

// File: rtl/irq_status_mask_ctrl.sv
module irq_status_mask_ctrl
  import irq_status_mask_pkg::*;
#(
  parameter int W = StatW,
  parameter logic [W-1:0] ClrMask = ClearableBits
) (
  input  logic         statusWrEn,
  input  logic [W-1:0] statusWrData,
  input  logic         unmaskWrEn,
  input  logic [W-1:0] unmaskWrData,
  input  logic         maskWrEn,
  input  logic [W-1:0] maskWrData,
  output ctrlStrobes_t strobes
);
  always_comb begin
    strobes.clrBits    = statusWrEn ? (statusWrData & ClrMask) : '0;
    strobes.unmaskBits = unmaskWrEn ? unmaskWrData : '0;
    strobes.maskBits   = maskWrEn   ? maskWrData   : '0;
  end
endmodule

// File: rtl/irq_status_mask_dp.sv
module irq_status_mask_dp
  import irq_status_mask_pkg::*;
#(
  parameter int W = StatW,
  parameter int E = EvtW,
  parameter logic [W-1:0] MaskRst = MaskResetVal
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [E-1:0] eventSet,
  input  ctrlStrobes_t strobes,
  output logic [W-1:0] statusQ,
  output logic [W-1:0] maskQ,
  output logic         irqOut
);
  localparam int PadW = W - E;
  localparam logic [W-1:0] SrcBits = {{PadW{1'b0}}, {E{1'b1}}};

  logic [W-1:0] setVec;
  logic [W-1:0] statusNext;
  logic [W-1:0] maskNext;

  assign setVec = {{PadW{1'b0}}, eventSet};

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      always_comb begin
        statusNext[i] = setVec[i] | (statusQ[i] & ~strobes.clrBits[i]);
        maskNext[i]   = strobes.maskBits[i] | (maskQ[i] & ~strobes.unmaskBits[i]);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      maskQ   <= MaskRst;
      irqOut  <= 1'b0;
    end else begin
      statusQ <= statusNext;
      maskQ   <= maskNext;
      irqOut  <= |(statusQ & ~maskQ);
    end
  end

  assert_set_sticks_R2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusQ & $past(setVec)) == $past(setVec)));
  // R8: set also wins over a same-cycle clear (covered by the check above)
  assert_clear_works_R3: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusQ & $past(strobes.clrBits & ~setVec)) == '0));
  assert_no_source_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ & ~SrcBits) == '0);
  assert_unmask_R5: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((maskQ & $past(strobes.unmaskBits & ~strobes.maskBits)) == '0));
  assert_mask_R6: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((maskQ & $past(strobes.maskBits)) == $past(strobes.maskBits)));
  assert_irq_settled_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(statusQ) && $stable(maskQ)) |-> (irqOut == |(statusQ & ~maskQ)));
endmodule

// File: rtl/irq_status_mask.sv
module irq_status_mask
  import irq_status_mask_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [EvtW-1:0]  eventSet,
  input  logic             statusWrEn,
  input  logic [StatW-1:0] statusWrData,
  input  logic             unmaskWrEn,
  input  logic [StatW-1:0] unmaskWrData,
  input  logic             maskWrEn,
  input  logic [StatW-1:0] maskWrData,
  output logic [StatW-1:0] statusQ,
  output logic [StatW-1:0] maskQ,
  output logic             irqOut
);
  ctrlStrobes_t strobes;

  irq_status_mask_ctrl #(.W(StatW), .ClrMask(ClearableBits)) u_ctrl (
    .statusWrEn(statusWrEn), .statusWrData(statusWrData),
    .unmaskWrEn(unmaskWrEn), .unmaskWrData(unmaskWrData),
    .maskWrEn(maskWrEn), .maskWrData(maskWrData),
    .strobes(strobes)
  );

  irq_status_mask_dp #(.W(StatW), .E(EvtW), .MaskRst(MaskResetVal)) u_dp (
    .clk(clk), .rstN(rstN), .eventSet(eventSet), .strobes(strobes),
    .statusQ(statusQ), .maskQ(maskQ), .irqOut(irqOut)
  );
endmodule

// File: tb/sim_irq_status_mask.sv
`timescale 1ns/1ps
module sim_irq_status_mask;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] eventSet = '0;
  logic statusWrEn = 1'b0, unmaskWrEn = 1'b0, maskWrEn = 1'b0;
  logic [9:0] statusWrData = '0, unmaskWrData = '0, maskWrData = '0;
  logic [9:0] statusQ, maskQ;
  logic irqOut;

  int checks = 0;
  int errors = 0;
  logic [9:0] expStatus, expMask;
  logic expIrq;

  always #10 clk = ~clk;

  irq_status_mask u0 (.*);

  function automatic logic [9:0] nextStatus(logic [9:0] s, logic [7:0] ev,
                                            logic we, logic [9:0] wd);
    logic [9:0] clr = we ? (wd & 10'h2FF) : 10'h000;
    return (s & ~clr) | {2'b00, ev};
  endfunction

  function automatic logic [9:0] nextMask(logic [9:0] m, logic ue, logic [9:0] ud,
                                          logic me, logic [9:0] md);
    logic [9:0] r = ue ? (m & ~ud) : m;
    return me ? (r | md) : r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(logic [7:0] ev, logic we, logic [9:0] wd, logic ue,
                      logic [9:0] ud, logic me, logic [9:0] md, string req);
    @(negedge clk);
    eventSet = ev; statusWrEn = we; statusWrData = wd;
    unmaskWrEn = ue; unmaskWrData = ud; maskWrEn = me; maskWrData = md;
    @(posedge clk);
    expIrq = |(expStatus & ~expMask);
    expStatus = nextStatus(expStatus, ev, we, wd);
    expMask = nextMask(expMask, ue, ud, me, md);
    @(negedge clk);
    eventSet = '0; statusWrEn = 0; unmaskWrEn = 0; maskWrEn = 0;
    check({req, " status"}, {22'd0, statusQ}, {22'd0, expStatus});
    check({req, " mask"}, {22'd0, maskQ}, {22'd0, expMask});
    check({req, " irq"}, {31'd0, irqOut}, {31'd0, expIrq});
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    expStatus = '0; expMask = 10'h2FF; expIrq = 1'b0;
    // R1 reset values
    check("R1 status", {22'd0, statusQ}, 32'h000);
    check("R1 mask", {22'd0, maskQ}, 32'h2FF);
    check("R1 irq", {31'd0, irqOut}, 32'd0);
    // R2 each event source sets its own bit
    for (int i = 0; i < 8; i++) step(8'(1 << i), 0, 0, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 0, 0, 0, "R2 hold");
    // R3 clear a single bit, zeros leave bits
    step(0, 1, 10'h004, 0, 0, 0, 0, "R3");
    step(0, 1, 10'h000, 0, 0, 0, 0, "R3 zero");
    // R4 writes to bits 8 and 9 change nothing
    step(0, 1, 10'h300, 0, 0, 0, 0, "R4");
    // R5 unmask bit 0 with status bit 0 set, R9 irq lags one cycle
    step(0, 0, 0, 1, 10'h001, 0, 0, "R5");
    check("R9 lag", {31'd0, irqOut}, 32'd0);
    step(0, 0, 0, 0, 0, 0, 0, "R9");
    check("R9 rise", {31'd0, irqOut}, 32'd1);
    // R6 mask bit 0 again
    step(0, 0, 0, 0, 0, 1, 10'h001, "R6");
    step(0, 0, 0, 0, 0, 0, 0, "R9 fall");
    check("R9 low", {31'd0, irqOut}, 32'd0);
    // R7 unmask and mask the same bits together
    step(0, 0, 0, 1, 10'h3FF, 1, 10'h0F0, "R7");
    // R8 set and clear the same bit together
    step(8'h08, 1, 10'h0FF, 0, 0, 0, 0, "R8");
    check("R8 bit3", {31'd0, statusQ[3]}, 32'd1);
    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] ev = ($urandom % 4 == 0) ? 8'($urandom) : 8'h00;
      logic we = ($urandom % 3 == 0);
      logic [9:0] wd = ($urandom % 4 == 0) ? 10'h3FF : 10'($urandom);
      logic ue = ($urandom % 5 == 0);
      logic [9:0] ud = ($urandom % 4 == 0) ? 10'h3FF : 10'($urandom);
      logic me = ($urandom % 5 == 0);
      logic [9:0] md = 10'($urandom);
      step(ev, we, wd, ue, ud, me, md, "R2 R3 R5 R6 R7 R8 R9 random");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule